// File: doc/BRIEF.md
# Debug-Port Bus Access Bridge

This block gives a JTAG debugger single-beat access to a 64-bit system bus. The debugger works through two scan registers. The control register carries an address, a transfer size and a direction flag. The data register is 32 bits wide. An external TAP controller delivers one Update-DR strobe per register, and the whole block runs on TCK. A control update with the direction flag clear starts a read. A data update while the direction flag is set starts a write. In both cases the bus request is raised one TCK edge after the strobe is taken, so TCK has to keep running after Update-DR for the access to happen.

Data is steered into byte lanes by size and by the low address bits, and matching byte enables are driven. A 64-bit transfer passes through the 32-bit data register in two scans. On a write, the first scan is held back and the bus sees one combined write after the second scan. On a read, one bus read fills both halves, and the upper half is handed out at the next data update without another bus access. A one-cycle ready pulse and a polled busy bit report completion. An event input is sampled on TCK edges.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After a control update with direction 0 (read) is accepted on a TCK edge, `bus_req` stays low for the next cycle and rises on the following edge.
- R2: A data update while the stored direction is 1 (write) starts a write for byte, halfword and word sizes. The one-edge gap before `bus_req` is the same as in R1. A control update with direction 1 starts no bus access.
- R3: `ready` goes high for exactly one cycle on the edge after the cycle in which `bus_req` and `bus_ack` are both high.
- R4: `event_seen` takes the value of `event_in` only on a TCK rising edge.
- R5: Size code 3 (doubleword) write: the first data update stores bus bits [31:0] and starts no access. The second data update issues one write with bits [63:32] from that update and byte enables 8'hFF.
- R6: Size code 3 read: one bus read. `dat_out` shows bits [31:0] afterwards. The next data update shows bits [63:32] and starts no bus access.
- R7: Size code 2 (word): address offset 3'b100 maps the data register onto bus bits [63:32] with enables 8'hF0. Offset 3'b000 maps it onto bits [31:0] with enables 8'h0F.
- R8: Size code 0 (byte) uses the lane at address bits [2:0]. Size code 1 (halfword) uses the lane pair at address bits [2:1]. Byte enables match the lanes, unselected lanes of `bus_wdata` are zero, and read data comes back right-aligned and zero-extended in `dat_out`.
- R9: Status bit `ctl_rb[AW+3]` (busy) is 1 from the edge that accepts a request until the edge that sees `bus_ack`.
- R10: A control update, or a write-mode data update, that arrives while busy is ignored: the stored fields are unchanged and no extra bus access occurs. It also sets error bit `ctl_rb[AW+4]`, which the next accepted control update clears.
- R11: Synchronous reset clears `ctl_rb`, `dat_out`, `ready`, `event_seen` and all bus outputs.
- R12: While `bus_req` is high without `bus_ack`, it stays high and `bus_addr` does not change.

Status layout in `ctl_rb`:
- bits [AW-1:0]: address
- bits [AW+1:AW]: size
- bit AW+2: direction
- bit AW+3: busy
- bit AW+4: error

`ctl_in` is packed as {direction, size, address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_ctl | input | 1 | Update-DR strobe for the control register |
| upd_dat | input | 1 | Update-DR strobe for the data register |
| ctl_in | input | AW+3 | Shifted-in control value {dir, size, addr} |
| dat_in | input | RW | Shifted-in data value |
| ctl_rb | output | AW+5 | Control and status readback |
| dat_out | output | RW | Data register readback |
| ready | output | 1 | One-cycle completion pulse |
| event_in | input | 1 | Event input pin |
| event_seen | output | 1 | Event input sampled on TCK |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write flag |
| bus_addr | output | AW | Bus address |
| bus_be | output | 2*RW/8 | Bus byte enables |
| bus_wdata | output | 2*RW | Bus write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 2*RW | Bus read data |

## Verification
The hardest case to reach from the ports is a second request that lands while the first is still outstanding. In normal traffic the bus answers before a debugger could scan again. The bench therefore lets its bus responder hold `bus_ack` back for a programmable number of cycles. With the acknowledge delayed, it fires a second control update into the busy window. It then checks that the error bit is set, that the stored address is unchanged, and that only one transaction reaches the bus.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/dbgb_lanes.sv
module dbgb_lanes
  import dbgb_pkg::*;
#(
  parameter int RW = 32
) (
  input  xfer_size_e          size,
  input  logic [$clog2(RW/4)-1:0] off,
  input  logic [RW-1:0]       wr_lo,
  input  logic [RW-1:0]       wr_hi,
  input  logic [2*RW-1:0]     rdata,
  output logic [RW/4-1:0]     be,
  output logic [2*RW-1:0]     wdata,
  output logic [RW-1:0]       rd_lo,
  output logic [RW-1:0]       rd_hi
);
  localparam int DW  = 2 * RW;
  localparam int BE  = DW / 8;
  localparam int OFW = $clog2(BE);

  logic [OFW:0]   nbytes;
  logic [OFW-1:0] aoff;
  logic [BE-1:0]  lo_w;
  logic [DW-1:0]  bmask;
  logic [DW-1:0]  lmask;

  always_comb begin
    nbytes = (OFW+1)'(1) << size;
    aoff   = off & ~(OFW'(nbytes - 1'b1));
  end

  for (genvar i = 0; i < BE; i++) begin : g_lane
    assign lo_w[i]          = (OFW+1)'(i) < nbytes;
    assign bmask[8*i +: 8]  = {8{be[i]}};
    assign lmask[8*i +: 8]  = {8{lo_w[i]}};
  end

  always_comb begin
    be    = lo_w << aoff;
    wdata = ({wr_hi, wr_lo} << {aoff, 3'b000}) & bmask;
    rd_lo = RW'((rdata >> {aoff, 3'b000}) & lmask);
    rd_hi = rdata[DW-1:RW];
  end

  always_comb begin
    AST_BE_NONZERO: assert (be != '0); // R8
  end
endmodule

// File: rtl/dbgb_seq.sv
module dbgb_seq #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_we,
  input  logic [AW-1:0]   addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic            ack,
  output logic            req,
  output logic            we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW/8-1:0] bus_be,
  output logic [DW-1:0]   bus_wdata,
  output logic            busy,
  output logic            done
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      req       <= 1'b0;
      we        <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
    end else begin
      done <= req && ack;
      if (start && !busy) begin
        armed     <= 1'b1;
        busy      <= 1'b1;
        we        <= start_we;
        bus_addr  <= addr;
        bus_be    <= be;
        bus_wdata <= start_we ? wdata : '0;
      end
      if (armed) begin
        armed <= 1'b0;
        req   <= 1'b1;
      end
      if (req && ack) begin
        req  <= 1'b0;
        busy <= 1'b0;
      end
    end
  end

  AST_START_GAP: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> !req) // R1
  ;
  AST_ARM_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    armed |=> req) // R1
  ;
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(bus_addr)) // R12
  ;
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) // R3
  ;
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> !busy && done) // R9
  ;
endmodule

// File: rtl/dbgb_evt.sv
module dbgb_evt #(
  parameter int STG = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STG-1:0] sh;

  if (STG == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= din;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STG-2:0], din};
    end
  end

  assign dout = sh[STG-1];
endmodule

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge
  import dbgb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int RW      = 32,
  parameter int EVT_STG = 1
) (
  input  logic                tck,
  input  logic                rst,
  input  logic                upd_ctl,
  input  logic                upd_dat,
  input  logic [AW+2:0]       ctl_in,
  input  logic [RW-1:0]       dat_in,
  output logic [AW+4:0]       ctl_rb,
  output logic [RW-1:0]       dat_out,
  output logic                ready,
  input  logic                event_in,
  output logic                event_seen,
  output logic                bus_req,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [2*RW/8-1:0]   bus_be,
  output logic [2*RW-1:0]     bus_wdata,
  input  logic                bus_ack,
  input  logic [2*RW-1:0]     bus_rdata
);
  localparam int DW  = 2 * RW;
  localparam int BE  = DW / 8;
  localparam int OFW = $clog2(BE);

  logic [AW-1:0] ctl_addr;
  xfer_size_e    ctl_size;
  logic          ctl_rw;
  logic          err;
  logic          dw_pass;
  logic          hi_pend;
  logic [RW-1:0] lo_save;
  logic [RW-1:0] hi_save;
  logic          busy;

  logic          in_rw;
  xfer_size_e    in_size;
  logic [AW-1:0] in_addr;
  logic          ctl_take, dat_take, rd_go, wr_go, collide, hi_step;
  xfer_size_e    size_sel;
  logic [AW-1:0] addr_sel;
  logic [BE-1:0] ln_be;
  logic [DW-1:0] ln_wdata;
  logic [RW-1:0] ln_rd_lo, ln_rd_hi, wr_lo_sel;

  always_comb begin
    in_rw     = ctl_in[AW+2];
    in_size   = xfer_size_e'(ctl_in[AW+1:AW]);
    in_addr   = ctl_in[AW-1:0];
    ctl_take  = upd_ctl && !busy;
    dat_take  = upd_dat && !busy && ctl_rw;
    rd_go     = ctl_take && !in_rw;
    wr_go     = dat_take && (ctl_size != SZ_DWORD || dw_pass);
    collide   = busy && (upd_ctl || (upd_dat && ctl_rw));
    hi_step   = upd_dat && !busy && !ctl_rw && hi_pend;
    size_sel  = ctl_take ? in_size : ctl_size;
    addr_sel  = ctl_take ? in_addr : ctl_addr;
    wr_lo_sel = (ctl_size == SZ_DWORD) ? lo_save : dat_in;
  end

  dbgb_lanes #(.RW(RW)) u_lanes (
    .size  (size_sel),
    .off   (addr_sel[OFW-1:0]),
    .wr_lo (wr_lo_sel),
    .wr_hi (dat_in),
    .rdata (bus_rdata),
    .be    (ln_be),
    .wdata (ln_wdata),
    .rd_lo (ln_rd_lo),
    .rd_hi (ln_rd_hi)
  );

  dbgb_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (tck),
    .rst       (rst),
    .start     (rd_go || wr_go),
    .start_we  (wr_go),
    .addr      (addr_sel),
    .be        (ln_be),
    .wdata     (ln_wdata),
    .ack       (bus_ack),
    .req       (bus_req),
    .we        (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (ready)
  );

  dbgb_evt #(.STG(EVT_STG)) u_evt (
    .clk  (tck),
    .rst  (rst),
    .din  (event_in),
    .dout (event_seen)
  );

  always_ff @(posedge tck) begin
    if (rst) begin
      ctl_addr <= '0;
      ctl_size <= SZ_BYTE;
      ctl_rw   <= 1'b0;
      err      <= 1'b0;
      dw_pass  <= 1'b0;
      hi_pend  <= 1'b0;
      lo_save  <= '0;
      hi_save  <= '0;
      dat_out  <= '0;
    end else begin
      if (ctl_take) begin
        ctl_addr <= in_addr;
        ctl_size <= in_size;
        ctl_rw   <= in_rw;
        err      <= 1'b0;
        dw_pass  <= 1'b0;
        hi_pend  <= 1'b0;
      end else if (collide) begin
        err <= 1'b1;
      end
      if (dat_take && ctl_size == SZ_DWORD && !dw_pass) begin
        lo_save <= dat_in;
        dw_pass <= 1'b1;
      end
      if (wr_go) dw_pass <= 1'b0;
      if (hi_step) begin
        dat_out <= hi_save;
        hi_pend <= 1'b0;
      end
      if (bus_req && bus_ack && !bus_we) begin
        dat_out <= ln_rd_lo;
        hi_save <= ln_rd_hi;
        hi_pend <= (ctl_size == SZ_DWORD);
      end
    end
  end

  assign ctl_rb = {err, busy, ctl_rw, ctl_size, ctl_addr};

  AST_ERR_ON_COLLIDE: assert property (@(posedge tck) disable iff (rst)
    upd_ctl && busy |=> err) // R10
  ;
  AST_DW_FIRST_PASS_IDLE: assert property (@(posedge tck) disable iff (rst)
    dat_take && ctl_size == SZ_DWORD && !dw_pass |=> !busy) // R5
  ;
  AST_HI_STEP_IDLE: assert property (@(posedge tck) disable iff (rst)
    hi_step |=> !busy && !hi_pend) // R6
  ;
endmodule

// File: tb/dbg_bus_bridge_test.sv
`timescale 1ns/1ps
module dbg_bus_bridge_test;
  localparam int AW = 32;
  localparam int RW = 32;
  localparam int BUSY_B = AW + 3;
  localparam int ERR_B  = AW + 4;
  localparam logic [63:0] RDATA = 64'h1122334455667788;
  localparam logic [31:0] WDAT  = 32'hA1B2C3D4;
  localparam logic [31:0] BASE  = 32'h2000_1000;

  // {size[1:0], offset[2:0], be[7:0], wdata[63:0], read result[31:0]}
  localparam logic [108:0] VEC [6] = '{
    {2'd0, 3'd5, 8'h20, 64'h0000D40000000000, 32'h00000033},
    {2'd1, 3'd3, 8'h0C, 64'h00000000C3D40000, 32'h00005566},
    {2'd2, 3'd4, 8'hF0, 64'hA1B2C3D400000000, 32'h11223344},
    {2'd2, 3'd0, 8'h0F, 64'h00000000A1B2C3D4, 32'h55667788},
    {2'd0, 3'd0, 8'h01, 64'h00000000000000D4, 32'h00000088},
    {2'd1, 3'd7, 8'hC0, 64'hC3D4000000000000, 32'h00001122}
  };

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic upd_ctl = 1'b0, upd_dat = 1'b0, event_in = 1'b0, bus_ack = 1'b0;
  logic [AW+2:0] ctl_in = '0;
  logic [RW-1:0] dat_in = '0;
  logic [AW+4:0] ctl_rb;
  logic [RW-1:0] dat_out;
  logic ready, event_seen, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_be;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata = RDATA;

  int n_chk = 0, n_bad = 0, lat = 0, lat_cnt = 0;
  int txn_cnt = 0, rdy_cnt = 0;
  logic in_txn = 1'b0, t_we = 1'b0;
  logic [7:0] t_be = '0;
  logic [63:0] t_wdata = '0;
  logic [31:0] t_addr = '0;
  bit done_flag = 1'b0;

  always #2 tck = ~tck;

  dbg_bus_bridge #(.AW(AW), .RW(RW)) uut (
    .tck(tck), .rst(rst), .upd_ctl(upd_ctl), .upd_dat(upd_dat),
    .ctl_in(ctl_in), .dat_in(dat_in), .ctl_rb(ctl_rb), .dat_out(dat_out),
    .ready(ready), .event_in(event_in), .event_seen(event_seen),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  always @(negedge tck) begin
    if (rst) begin
      bus_ack = 1'b0; lat_cnt = 0; in_txn = 1'b0;
    end else begin
      if (ready) rdy_cnt++;
      if (bus_req && !in_txn) begin
        txn_cnt++; in_txn = 1'b1;
        t_we = bus_we; t_be = bus_be; t_wdata = bus_wdata; t_addr = bus_addr;
      end
      if (!bus_req) in_txn = 1'b0;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (lat_cnt >= lat) begin bus_ack = 1'b1; lat_cnt = 0; end
        else lat_cnt++;
      end
    end
  end

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_ctl(logic rw, logic [1:0] sz, logic [31:0] a);
    ctl_in = {rw, sz, a}; upd_ctl = 1'b1; tick(); upd_ctl = 1'b0;
  endtask

  task automatic do_dat(logic [31:0] d);
    dat_in = d; upd_dat = 1'b1; tick(); upd_dat = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      if (!ctl_rb[BUSY_B]) break;
      tick();
    end
    tick();
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int t0, r0;
    repeat (3) tick();
    rst = 1'b0;
    // R11 reset state
    check("R11 ctl_rb", 64'(ctl_rb), 64'h0);
    check("R11 dat_out", 64'(dat_out), 64'h0);
    check("R11 outs", {60'h0, ready, event_seen, bus_req, bus_we}, 64'h0);

    // table: write then read per entry
    for (int i = 0; i < 6; i++) begin
      logic [108:0] v;
      logic [31:0] a;
      v = VEC[i];
      a = BASE | {29'h0, v[106:104]};
      t0 = txn_cnt;
      do_ctl(1'b1, v[108:107], a);
      do_dat(WDAT);
      wait_idle();
      check("R7/R8 write count", 64'(txn_cnt - t0), 64'd1);
      check("R7/R8 be", 64'(t_be), 64'(v[103:96]));
      check("R7/R8 wdata", t_wdata, v[95:32]);
      check("R7/R8 addr", {t_we, t_addr}, {1'b1, a});
      do_ctl(1'b0, v[108:107], a);
      wait_idle();
      check("R7/R8 read data", 64'(dat_out), 64'(v[31:0]));
    end

    // R1 read start gap, R9 busy, R12 hold, R3 ready pulse
    lat = 3; r0 = rdy_cnt;
    do_ctl(1'b0, 2'd2, BASE);
    check("R9 busy set", 64'(ctl_rb[BUSY_B]), 64'd1);
    check("R1 no req yet", 64'(bus_req), 64'd0);
    tick();
    check("R1 req raised", 64'(bus_req), 64'd1);
    tick();
    check("R12 req held", {bus_req, bus_addr}, {1'b1, BASE});
    wait_idle();
    check("R9 busy clear", 64'(ctl_rb[BUSY_B]), 64'd0);
    check("R3 one ready cycle", 64'(rdy_cnt - r0), 64'd1);

    // R2 write start gap; control write alone starts nothing
    lat = 0; t0 = txn_cnt;
    do_ctl(1'b1, 2'd2, BASE);
    tick();
    check("R2 ctl write no access", {63'(txn_cnt - t0), ctl_rb[BUSY_B]}, 64'h0);
    do_dat(32'h0BADF00D);
    check("R2 no req yet", 64'(bus_req), 64'd0);
    tick();
    check("R2 req raised", 64'(bus_req), 64'd1);
    wait_idle();

    // R5 doubleword write
    t0 = txn_cnt;
    do_ctl(1'b1, 2'd3, BASE);
    do_dat(32'h55667788);
    tick(); tick();
    check("R5 first pass idle", 64'(txn_cnt - t0), 64'd0);
    do_dat(32'h11223344);
    wait_idle();
    check("R5 one write", 64'(txn_cnt - t0), 64'd1);
    check("R5 wdata", t_wdata, 64'h1122334455667788);
    check("R5 be", 64'(t_be), 64'hFF);

    // R6 doubleword read
    t0 = txn_cnt;
    do_ctl(1'b0, 2'd3, BASE);
    wait_idle();
    check("R6 lower half", 64'(dat_out), 64'h55667788);
    do_dat(32'h0);
    tick();
    check("R6 upper half", 64'(dat_out), 64'h11223344);
    check("R6 single read", 64'(txn_cnt - t0), 64'd1);

    // R10 collision
    lat = 10; t0 = txn_cnt;
    do_ctl(1'b0, 2'd2, BASE);
    tick();
    do_ctl(1'b0, 2'd0, 32'h3000_0005);
    check("R10 err set", 64'(ctl_rb[ERR_B]), 64'd1);
    check("R10 addr kept", 64'(ctl_rb[AW-1:0]), 64'(BASE));
    wait_idle();
    check("R10 one access", 64'(txn_cnt - t0), 64'd1);
    lat = 0;
    do_ctl(1'b1, 2'd2, BASE);
    check("R10 err cleared", 64'(ctl_rb[ERR_B]), 64'd0);

    // R4 event sampling
    event_in = 1'b1;
    #0.5;
    check("R4 not yet sampled", 64'(event_seen), 64'd0);
    tick();
    check("R4 sampled high", 64'(event_seen), 64'd1);
    event_in = 1'b0;
    tick();
    check("R4 sampled low", 64'(event_seen), 64'd0);

    report();
  end
endmodule